// File: doc/BRIEF.md
# Privileged Register Hazard Monitor

This block observes an instruction stream, at most one instruction per clock, and judges every move to or from a privileged processor register against a set of sequencing rules. It decodes an opcode class, a target register number, the current PAL-mode bit and, for return-from-interrupt instructions, the PAL bit of the return address. It does not hold any register contents itself. For each move it reports whether the move takes effect or is suppressed. It also raises a one-cycle violation with a 3-bit code whenever the sequence breaks a rule.

The registers in scope are the three instruction translation buffer registers (tag, PTE and PTE-temp) and the PAL base register. Two status inputs come from elsewhere in the core: the trap-shadow condition and the machine-check enable. A machine-check fault indication can accompany any instruction. When it lands on a move that has already completed, the monitor warns that the saved restart address points at that move, so the move must not be run a second time.

Encodings: class `00` is any other instruction, `01` is a move to a register (write), `10` is a move from a register (read), and `11` is a return-from-interrupt. Register numbers are 0 for the ITB tag, 1 for the ITB PTE, 2 for the ITB PTE-temp and 3 for the PAL base. Numbers 4 to 7 are other privileged registers. A cycle with `ins_valid` low is a null cycle.

Top module: `privreg_hazard_mon`

## Requirements
- R1: A move (class 01 or 10) to register 0, 1 or 2 while `pal_mode` is 0 is suppressed and reported with violation code 1.
- R2: A move to register 0, 1 or 2 in the cycle right after a return (class 11) with `rei_to_pal` set is suppressed and reported with code 2. Any instruction or null cycle in between removes this effect.
- R3: An effective write to register 0 is flagged with code 3 when fewer than two null cycles have passed since the last effective write to register 1. The write still takes effect. Valid instructions do not count toward the gap. With no effective write to register 1 since reset, nothing is flagged.
- R4: A write to register 3 is flagged with code 4 unless `pal_mode` is 1, `mchk_en` is 0 and `trap_shadow` is 0. The write still takes effect. Reads of register 3 are never flagged.
- R5: An effective move that carries `mchk_fault` raises `restart_bad` and code 5. A suppressed move or a non-move instruction with `mchk_fault` raises neither.
- R6: One code is reported per instruction, with priority 1 > 2 > 3 > 4 > 5. Code 0 means no violation, and `viol` is high exactly when the code is nonzero.
- R7: All outputs are registered and describe the instruction sampled at the previous clock edge. A single offending instruction produces a `viol` pulse of exactly one cycle. `mv_done` and `mv_blocked` are never both high.
- R8: Synchronous active-high reset clears every output and all history. The first instruction after reset is never treated as following a return, and no earlier PTE write is assumed.
- R9: Moves to registers 4 to 7 always take effect, whatever the mode, and are never flagged except under R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction present this cycle (low = null cycle) |
| ins_class | input | 2 | 00 other, 01 write, 10 read, 11 return |
| ins_reg | input | 3 | Target privileged register number |
| pal_mode | input | 1 | Core is in PAL mode |
| rei_to_pal | input | 1 | Return target address has its PAL bit set |
| trap_shadow | input | 1 | Core is inside an arithmetic trap shadow |
| mchk_en | input | 1 | Machine checks enabled |
| mchk_fault | input | 1 | Machine check reported as a fault on this instruction |
| mv_seen | output | 1 | Previous instruction was a move |
| mv_done | output | 1 | That move took effect |
| mv_blocked | output | 1 | That move was suppressed |
| viol | output | 1 | Rule violation pulse |
| viol_code | output | 3 | Violation code, 0 when none |
| restart_bad | output | 1 | Restart address points at an already completed move |

## Verification
The bench sends a PTE write followed by zero, one and two null cycles before a tag write, and inserts ordinary instructions that must not count as gaps. A design that counted every cycle, or that never saturated, would flag the wrong one of these. It places a return to PAL directly before an ITB move, and also one null cycle before it, to catch a hazard flag that lingers for too long. It also tries an ITB move outside PAL mode right after such a return, which must report code 1 and not code 2. Machine-check faults are placed on suppressed moves, on non-moves and on unsafe PAL base writes. A design that ignored suppression or got the code priority wrong would raise `restart_bad` or report code 5 where it must not.

// File: rtl/privreg_hazard_mon.sv
module privreg_hazard_mon #(
  parameter int NULL_GAP = 2,
  parameter int REG_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic [1:0]       ins_class,
  input  logic [REG_W-1:0] ins_reg,
  input  logic             pal_mode,
  input  logic             rei_to_pal,
  input  logic             trap_shadow,
  input  logic             mchk_en,
  input  logic             mchk_fault,
  output logic             mv_seen,
  output logic             mv_done,
  output logic             mv_blocked,
  output logic             viol,
  output logic [2:0]       viol_code,
  output logic             restart_bad
);
  localparam int CW = $clog2(NULL_GAP + 1);
  localparam logic [CW-1:0] GAP_MAX = CW'(NULL_GAP);
  localparam logic [1:0] C_WR  = 2'd1;
  localparam logic [1:0] C_RD  = 2'd2;
  localparam logic [1:0] C_REI = 2'd3;
  localparam logic [REG_W-1:0] R_TAG   = REG_W'(0);
  localparam logic [REG_W-1:0] R_PTE   = REG_W'(1);
  localparam logic [REG_W-1:0] R_PTMP  = REG_W'(2);
  localparam logic [REG_W-1:0] R_PBASE = REG_W'(3);

  logic          rei_pal_q;
  logic          pte_arm_q;
  logic [CW-1:0] gap_q;
  logic [2:0]    code_d;

  wire is_mv  = ins_valid && (ins_class == C_WR || ins_class == C_RD);
  wire is_wr  = ins_valid && ins_class == C_WR;
  wire is_rei = ins_valid && ins_class == C_REI;
  wire itb    = ins_reg == R_TAG || ins_reg == R_PTE || ins_reg == R_PTMP;

  wire e_nopal = is_mv && itb && !pal_mode;
  wire e_rei   = is_mv && itb && rei_pal_q;
  wire blk     = e_nopal || e_rei;
  wire done    = is_mv && !blk;
  wire pte_wr  = done && is_wr && ins_reg == R_PTE;
  wire e_gap   = done && is_wr && ins_reg == R_TAG && pte_arm_q && gap_q < GAP_MAX;
  wire e_pbase = done && is_wr && ins_reg == R_PBASE && (!pal_mode || mchk_en || trap_shadow);
  wire e_rst   = done && mchk_fault;

  always_comb begin
    if (e_nopal)      code_d = 3'd1;
    else if (e_rei)   code_d = 3'd2;
    else if (e_gap)   code_d = 3'd3;
    else if (e_pbase) code_d = 3'd4;
    else if (e_rst)   code_d = 3'd5;
    else              code_d = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rei_pal_q <= 1'b0;
      pte_arm_q <= 1'b0;
      gap_q     <= '0;
    end else begin
      rei_pal_q <= is_rei && rei_to_pal;
      if (pte_wr) begin
        pte_arm_q <= 1'b1;
        gap_q     <= '0;
      end else if (!ins_valid && gap_q < GAP_MAX) begin
        gap_q <= gap_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mv_seen     <= 1'b0;
      mv_done     <= 1'b0;
      mv_blocked  <= 1'b0;
      viol        <= 1'b0;
      viol_code   <= 3'd0;
      restart_bad <= 1'b0;
    end else begin
      mv_seen     <= is_mv;
      mv_done     <= done;
      mv_blocked  <= blk;
      viol        <= code_d != 3'd0;
      viol_code   <= code_d;
      restart_bad <= e_rst;
    end
  end
endmodule

// File: rtl/privreg_hazard_mon_chk.sv
module privreg_hazard_mon_chk #(
  parameter int REG_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ins_valid,
  input logic [1:0]       ins_class,
  input logic [REG_W-1:0] ins_reg,
  input logic             pal_mode,
  input logic             rei_to_pal,
  input logic             trap_shadow,
  input logic             mchk_en,
  input logic             mchk_fault,
  input logic             mv_seen,
  input logic             mv_done,
  input logic             mv_blocked,
  input logic             viol,
  input logic [2:0]       viol_code,
  input logic             restart_bad
);
  logic saw_rei_pal;
  wire  mv    = ins_valid && (ins_class == 2'd1 || ins_class == 2'd2);
  wire  itb_r = ins_reg < REG_W'(3);

  always_ff @(posedge clk) begin
    if (rst) saw_rei_pal <= 1'b0;
    else     saw_rei_pal <= ins_valid && ins_class == 2'd3 && rei_to_pal;
  end

  p_nopal_block_r1: assert property (@(posedge clk) disable iff (rst)
    (mv && itb_r && !pal_mode) |=> (mv_blocked && viol_code == 3'd1));

  p_rei_block_r2: assert property (@(posedge clk) disable iff (rst)
    (saw_rei_pal && mv && itb_r && pal_mode) |=> (mv_blocked && viol_code == 3'd2));

  p_pbase_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_class == 2'd1 && ins_reg == REG_W'(3) && pal_mode && (mchk_en || trap_shadow))
    |=> (mv_done && viol_code == 3'd4));

  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (mv && !itb_r && mchk_fault) |=> restart_bad);

  p_blocked_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
    mv_blocked |-> !restart_bad);

  p_code_viol_r6: assert property (@(posedge clk) disable iff (rst)
    viol == (viol_code != 3'd0));

  p_done_xor_blk_r7: assert property (@(posedge clk) disable iff (rst)
    !(mv_done && mv_blocked) && (mv_seen == (mv_done || mv_blocked)));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!viol && !mv_seen && !restart_bad));
endmodule

bind privreg_hazard_mon privreg_hazard_mon_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/privreg_hazard_mon_test.sv
module privreg_hazard_mon_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_valid = 1'b0;
  logic [1:0] ins_class = 2'd0;
  logic [2:0] ins_reg = 3'd0;
  logic pal_mode = 1'b0, rei_to_pal = 1'b0, trap_shadow = 1'b0;
  logic mchk_en = 1'b0, mchk_fault = 1'b0;
  logic mv_seen, mv_done, mv_blocked, viol, restart_bad;
  logic [2:0] viol_code;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  privreg_hazard_mon uut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_class(ins_class),
    .ins_reg(ins_reg), .pal_mode(pal_mode), .rei_to_pal(rei_to_pal),
    .trap_shadow(trap_shadow), .mchk_en(mchk_en), .mchk_fault(mchk_fault),
    .mv_seen(mv_seen), .mv_done(mv_done), .mv_blocked(mv_blocked),
    .viol(viol), .viol_code(viol_code), .restart_bad(restart_bad));

  task automatic expect_out(string req, bit d, bit b, logic [2:0] c, bit r);
    logic [7:0] got, exp;
    got = {mv_seen, mv_done, mv_blocked, viol, viol_code, restart_bad};
    exp = {d | b, d, b, c != 3'd0, c, r};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got seen/done/blk/viol/code/rst=%b expected %b", req, got, exp);
    end
  endtask

  task automatic issue(bit v, logic [1:0] cls, logic [2:0] rg, bit pal,
                       bit rp = 0, bit ts = 0, bit me = 0, bit mf = 0);
    ins_valid = v; ins_class = cls; ins_reg = rg; pal_mode = pal;
    rei_to_pal = rp; trap_shadow = ts; mchk_en = me; mchk_fault = mf;
    @(posedge clk);
    #1;
  endtask

  task automatic bubble();
    issue(0, 2'd0, 3'd0, 1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    issue(0, 2'd0, 3'd0, 0);
    issue(0, 2'd0, 3'd0, 0);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    issue(1, 2'd1, 3'd0, 0, 0, 1, 1, 1);
    expect_out("R8 outputs in reset", 0, 0, 3'd0, 0);
    issue(1, 2'd3, 3'd0, 1, 1);
    rst = 1'b0;
    issue(1, 2'd1, 3'd0, 1);
    expect_out("R8 no return history after reset", 1, 0, 3'd0, 0);
  endtask

  task automatic t_outside_pal();
    do_reset();
    issue(1, 2'd1, 3'd0, 0);
    expect_out("R1 tag write outside PAL", 0, 1, 3'd1, 0);
    issue(1, 2'd2, 3'd2, 0);
    expect_out("R1 pte-temp read outside PAL", 0, 1, 3'd1, 0);
    issue(1, 2'd1, 3'd1, 0);
    expect_out("R1 pte write outside PAL", 0, 1, 3'd1, 0);
    issue(1, 2'd1, 3'd5, 0);
    expect_out("R9 other register outside PAL", 1, 0, 3'd0, 0);
    bubble();
    expect_out("R7 pulse ends after one cycle", 0, 0, 3'd0, 0);
    issue(1, 2'd2, 3'd0, 1);
    expect_out("R1 tag read in PAL", 1, 0, 3'd0, 0);
  endtask

  task automatic t_after_rei();
    do_reset();
    issue(1, 2'd3, 3'd0, 1, 1);
    expect_out("R2 return itself", 0, 0, 3'd0, 0);
    issue(1, 2'd1, 3'd0, 1);
    expect_out("R2 tag write right after return", 0, 1, 3'd2, 0);
    issue(1, 2'd1, 3'd0, 1);
    expect_out("R2 second cycle after return", 1, 0, 3'd0, 0);
    issue(1, 2'd3, 3'd0, 1, 1);
    bubble();
    issue(1, 2'd2, 3'd1, 1);
    expect_out("R2 null cycle clears return hazard", 1, 0, 3'd0, 0);
    issue(1, 2'd3, 3'd0, 1, 0);
    issue(1, 2'd2, 3'd2, 1);
    expect_out("R2 return to non-PAL address", 1, 0, 3'd0, 0);
    issue(1, 2'd3, 3'd0, 1, 1);
    issue(1, 2'd2, 3'd1, 1);
    expect_out("R2 pte read right after return", 0, 1, 3'd2, 0);
    issue(1, 2'd3, 3'd0, 1, 1);
    issue(1, 2'd2, 3'd6, 1);
    expect_out("R2 R9 non-ITB move after return", 1, 0, 3'd0, 0);
    issue(1, 2'd3, 3'd0, 1, 1);
    issue(1, 2'd1, 3'd2, 0);
    expect_out("R6 outside PAL beats after-return", 0, 1, 3'd1, 0);
  endtask

  task automatic t_pte_tag();
    do_reset();
    issue(1, 2'd1, 3'd0, 1);
    expect_out("R3 R8 tag write with no PTE history", 1, 0, 3'd0, 0);
    issue(1, 2'd1, 3'd1, 1);
    expect_out("R3 pte write", 1, 0, 3'd0, 0);
    issue(1, 2'd1, 3'd0, 1);
    expect_out("R3 tag right after pte", 1, 0, 3'd3, 0);
    issue(1, 2'd1, 3'd1, 1);
    bubble();
    issue(1, 2'd1, 3'd0, 1);
    expect_out("R3 tag after one null cycle", 1, 0, 3'd3, 0);
    issue(1, 2'd1, 3'd1, 1);
    bubble();
    bubble();
    issue(1, 2'd1, 3'd0, 1);
    expect_out("R3 tag after two null cycles", 1, 0, 3'd0, 0);
    issue(1, 2'd1, 3'd1, 1);
    issue(1, 2'd0, 3'd0, 1);
    bubble();
    issue(1, 2'd1, 3'd0, 1);
    expect_out("R3 valid instruction is not a gap", 1, 0, 3'd3, 0);
    issue(1, 2'd1, 3'd1, 1);
    issue(1, 2'd0, 3'd0, 1);
    bubble(); bubble(); bubble(); bubble();
    issue(1, 2'd1, 3'd0, 1);
    expect_out("R3 saturated gap", 1, 0, 3'd0, 0);
    issue(1, 2'd1, 3'd1, 0);
    expect_out("R3 R1 suppressed pte write", 0, 1, 3'd1, 0);
    issue(1, 2'd1, 3'd0, 1);
    expect_out("R3 suppressed pte does not rearm", 1, 0, 3'd0, 0);
    issue(1, 2'd1, 3'd1, 1);
    issue(1, 2'd2, 3'd0, 1);
    expect_out("R3 tag read is not flagged", 1, 0, 3'd0, 0);
  endtask

  task automatic t_palbase();
    do_reset();
    issue(1, 2'd1, 3'd3, 1);
    expect_out("R4 safe pal base write", 1, 0, 3'd0, 0);
    issue(1, 2'd1, 3'd3, 1, 0, 0, 1);
    expect_out("R4 pal base with machine checks on", 1, 0, 3'd4, 0);
    issue(1, 2'd1, 3'd3, 1, 0, 1, 0);
    expect_out("R4 pal base in trap shadow", 1, 0, 3'd4, 0);
    issue(1, 2'd1, 3'd3, 0);
    expect_out("R4 pal base outside PAL", 1, 0, 3'd4, 0);
    issue(1, 2'd2, 3'd3, 0, 0, 1, 1);
    expect_out("R4 pal base read never flagged", 1, 0, 3'd0, 0);
  endtask

  task automatic t_restart();
    do_reset();
    issue(1, 2'd2, 3'd6, 1, 0, 0, 0, 1);
    expect_out("R5 fault on completed move", 1, 0, 3'd5, 1);
    issue(1, 2'd1, 3'd3, 1, 0, 0, 1, 1);
    expect_out("R5 R6 unsafe pal base with fault", 1, 0, 3'd4, 1);
    issue(1, 2'd1, 3'd0, 0, 0, 0, 0, 1);
    expect_out("R5 fault on suppressed move", 0, 1, 3'd1, 0);
    issue(1, 2'd0, 3'd6, 1, 0, 0, 0, 1);
    expect_out("R5 fault on non-move", 0, 0, 3'd0, 0);
    bubble();
    expect_out("R7 restart flag is a pulse", 0, 0, 3'd0, 0);
  endtask

  initial begin
    t_reset();
    t_outside_pal();
    t_after_rei();
    t_pte_tag();
    t_palbase();
    t_restart();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, got unfinished expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule